// File: doc/BRIEF.md
# Single-Page Block Copy Engine

This block moves a block of 32-bit words between a peripheral data port and system memory without processor help. Software sets up a starting physical address, a byte count, a transfer direction and a peripheral selector through four memory-mapped registers, then writes the start bit. The engine fetches each word from the source side, holds it in a one-word buffer and delivers it to the destination side. It requests the memory bus separately for every word.

Because addresses are physical, one programmed transfer must stay inside a single page. Page size is a parameter and defaults to 4096 bytes. A start command whose range would leave the page, or whose count or address is not word-aligned, moves no data. It sets an error flag and raises the interrupt instead. Software covers a longer buffer by issuing several page-bounded transfers in turn. The interrupt is raised only once the whole block has moved, and it stays high until software clears the flag.

Top module: `dma_page_engine`

## Requirements
- R1: After reset the status register reads 0, `irq` is low, and `memReq`, `devRxReady` and `devTxValid` are all low.
- R2: With the direction bit at 0, the engine takes `count/4` words from the peripheral receive port. It writes them to memory at the start address and the following addresses, stepping by 4.
- R3: With the direction bit at 1, the engine reads `count/4` words from memory starting at the start address, stepping by 4. It presents them in order on the peripheral transmit port.
- R4: Register map, selected by `regAddr`. Offset 0x0 is control: bit 0 is start (reads as 0), bit 1 is direction, and bits 7:4 are the peripheral selector, which is driven on `devSel`. Offset 0x4 is the start address. Offset 0x8 is the byte count. Offset 0xC is status: bit 0 busy, bit 1 done, bit 2 error.
- R5: A start with (address mod page size) + count greater than the page size sets error and `irq`. It makes no memory or peripheral access. A range that ends exactly on the page boundary is accepted.
- R6: A start with a count of zero, a count that is not a multiple of 4, or an address that is not a multiple of 4 sets error. It moves no data.
- R7: For each memory word the engine holds `memReq` (and `memWe`) steady until it sees `memGnt`. It drops `memReq` in the cycle after the grant, so every word raises its own request.
- R8: `irq` is high exactly while done or error is set. Done is set only after the last word completes, so `irq` stays low during a transfer.
- R9: Writing 1 to status bit 1 or bit 2 clears that flag. Writing 0 leaves it unchanged.
- R10: While busy, a start command is ignored, and writes to the control, address and count registers have no effect.
- R11: If the final word completes in the same cycle as a write that clears done, done ends up set.
- R12: An accepted start clears any earlier done and error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational on `regAddr`) |
| memReq | output | 1 | Memory bus request for one word |
| memWe | output | 1 | 1 = memory write, 0 = memory read |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid while `memGnt` is high |
| memGnt | input | 1 | Grant: the requested word access completes this cycle |
| devSel | output | 4 | Peripheral selector from the control register |
| devRxValid | input | 1 | Peripheral offers a word |
| devRxData | input | 32 | Word from peripheral |
| devRxReady | output | 1 | Engine accepts a peripheral word |
| devTxValid | output | 1 | Engine offers a word to peripheral |
| devTxData | output | 32 | Word to peripheral |
| devTxReady | input | 1 | Peripheral accepts the word |
| irq | output | 1 | Level interrupt: done or error set |

## Verification
Two functions can meet in the same cycle: setting done on the grant of the final memory write, and software clearing done through a status write. The bench holds back the memory grant for a one-word transfer until it chooses. It then issues the status write in exactly the cycle that carries the grant. Afterwards it requires done and `irq` to read 1, and checks that a later clear still removes the flag.

// File: rtl/dma_pkg.sv
package dma_pkg;
  // strobes from the sequencer to the datapath, one cycle each
  typedef struct packed {
    logic loadStart; // latch working address/count, clear flags
    logic errSet;    // reject the start command
    logic capture;   // load the word buffer from the source side
    logic advance;   // step address, reduce remaining count
    logic doneSet;   // last word delivered
  } dmaStrobe_t;
endpackage

// File: rtl/dma_dp.sv
module dma_dp
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [3:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              busy,
  input  dmaStrobe_t        strobe,
  output logic              startCmd,
  output logic              startBad,
  output logic              dir,
  output logic              lastWord,
  output logic [3:0]        devSel,
  output logic [ADDR_W-1:0] curAddr,
  output logic [DATA_W-1:0] bufData,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] devRxData,
  output logic              irq
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int LSB = $clog2(WORD_BYTES);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int SUM_W = ADDR_W + 1;
  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_ADDR = 4'h4;
  localparam logic [3:0] OFS_CNT  = 4'h8;
  localparam logic [3:0] OFS_STAT = 4'hC;

  logic [ADDR_W-1:0] addrReg, cntReg, remCount;
  logic [3:0] devReg;
  logic dirReg, done, errFlag;
  logic wrCtrl, wrAddr, wrCnt, wrStat;
  logic [SUM_W-1:0] pageSum;

  assign wrCtrl = regWe && regAddr == OFS_CTRL;
  assign wrAddr = regWe && regAddr == OFS_ADDR;
  assign wrCnt  = regWe && regAddr == OFS_CNT;
  assign wrStat = regWe && regAddr == OFS_STAT;
  assign startCmd = wrCtrl && regWdata[0];

  assign pageSum = SUM_W'(addrReg[OFF_W-1:0]) + SUM_W'(cntReg);
  assign startBad = (cntReg == '0) || (|cntReg[LSB-1:0]) || (|addrReg[LSB-1:0])
                    || (pageSum > SUM_W'(PAGE_BYTES));
  assign lastWord = remCount == ADDR_W'(WORD_BYTES);
  assign dir = dirReg;
  assign devSel = devReg;
  assign irq = done | errFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0; cntReg <= '0; remCount <= '0; curAddr <= '0;
      devReg <= '0; dirReg <= 1'b0; bufData <= '0;
      done <= 1'b0; errFlag <= 1'b0;
    end else begin
      if (!busy) begin
        if (wrCtrl) begin
          dirReg <= regWdata[1];
          devReg <= regWdata[7:4];
        end
        if (wrAddr) addrReg <= ADDR_W'(regWdata);
        if (wrCnt) cntReg <= ADDR_W'(regWdata);
      end
      if (strobe.loadStart) begin
        curAddr <= addrReg;
        remCount <= cntReg;
      end
      if (strobe.capture) bufData <= dirReg ? memRdata : devRxData;
      if (strobe.advance) begin
        curAddr <= curAddr + ADDR_W'(WORD_BYTES);
        remCount <= remCount - ADDR_W'(WORD_BYTES);
      end
      // clear first, set last: a same-cycle set wins
      if (wrStat && regWdata[1]) done <= 1'b0;
      if (wrStat && regWdata[2]) errFlag <= 1'b0;
      if (strobe.loadStart) begin
        done <= 1'b0;
        errFlag <= 1'b0;
      end
      if (strobe.doneSet) done <= 1'b1;
      if (strobe.errSet) errFlag <= 1'b1;
    end
  end

  always_comb begin
    unique case (regAddr)
      OFS_CTRL: regRdata = DATA_W'({devReg, 2'b00, dirReg, 1'b0});
      OFS_ADDR: regRdata = DATA_W'(addrReg);
      OFS_CNT:  regRdata = DATA_W'(cntReg);
      OFS_STAT: regRdata = DATA_W'({errFlag, done, busy});
      default:  regRdata = '0;
    endcase
  end

  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    irq && !wrStat && !strobe.loadStart |=> irq);
  p_busy_cfg_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(addrReg) && $stable(cntReg) && $stable(dirReg));
  p_done_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doneSet |=> done);
  p_start_clears_r12: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadStart |=> !errFlag && !done);
endmodule

// File: rtl/dma_ctl.sv
module dma_ctl
  import dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startCmd,
  input  logic       startBad,
  input  logic       dir,
  input  logic       lastWord,
  input  logic       memGnt,
  input  logic       devRxValid,
  input  logic       devTxReady,
  output dmaStrobe_t strobe,
  output logic       busy,
  output logic       memReq,
  output logic       memWe,
  output logic       devRxReady,
  output logic       devTxValid
);
  typedef enum logic [1:0] {ST_IDLE, ST_SRC, ST_DST} ctlState_t;
  ctlState_t state, nxt;
  logic fire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nxt;
  end

  always_comb begin
    strobe = '0;
    nxt = state;
    memReq = 1'b0;
    memWe = 1'b0;
    devRxReady = 1'b0;
    devTxValid = 1'b0;
    fire = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startCmd) begin
          if (startBad) strobe.errSet = 1'b1;
          else begin
            strobe.loadStart = 1'b1;
            nxt = ST_SRC;
          end
        end
      end
      ST_SRC: begin
        if (dir) begin
          memReq = 1'b1;
          fire = memGnt;
        end else begin
          devRxReady = 1'b1;
          fire = devRxValid;
        end
        if (fire) begin
          strobe.capture = 1'b1;
          nxt = ST_DST;
        end
      end
      default: begin
        if (dir) begin
          devTxValid = 1'b1;
          fire = devTxReady;
        end else begin
          memReq = 1'b1;
          memWe = 1'b1;
          fire = memGnt;
        end
        if (fire) begin
          strobe.advance = 1'b1;
          if (lastWord) begin
            strobe.doneSet = 1'b1;
            nxt = ST_IDLE;
          end else nxt = ST_SRC;
        end
      end
    endcase
  end

  assign busy = state != ST_IDLE;

  p_req_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memGnt |=> !memReq);
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memWe));
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq && !devRxReady && !devTxValid);
endmodule

// File: rtl/dma_page_engine.sv
module dma_page_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [3:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memGnt,
  output logic [3:0]        devSel,
  input  logic              devRxValid,
  input  logic [DATA_W-1:0] devRxData,
  output logic              devRxReady,
  output logic              devTxValid,
  output logic [DATA_W-1:0] devTxData,
  input  logic              devTxReady,
  output logic              irq
);
  dmaStrobe_t strobe;
  logic busy, startCmd, startBad, dir, lastWord;
  logic [DATA_W-1:0] bufData;

  dma_ctl uCtl (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .startBad(startBad),
    .dir(dir), .lastWord(lastWord), .memGnt(memGnt),
    .devRxValid(devRxValid), .devTxReady(devTxReady), .strobe(strobe),
    .busy(busy), .memReq(memReq), .memWe(memWe),
    .devRxReady(devRxReady), .devTxValid(devTxValid)
  );

  dma_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) uDp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busy(busy), .strobe(strobe),
    .startCmd(startCmd), .startBad(startBad), .dir(dir), .lastWord(lastWord),
    .devSel(devSel), .curAddr(memAddr), .bufData(bufData),
    .memRdata(memRdata), .devRxData(devRxData), .irq(irq)
  );

  assign memWdata = bufData;
  assign devTxData = bufData;
endmodule

// File: tb/sim_dma_page_engine.sv
`timescale 1ns/1ps
module sim_dma_page_engine;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [3:0] regAddr = 4'h0;
  logic [31:0] regWdata = '0, regRdata;
  logic memReq, memWe, memGnt = 1'b0;
  logic [31:0] memAddr, memWdata, memRdata = '0;
  logic [3:0] devSel;
  logic devRxValid, devRxReady, devTxValid, devTxReady;
  logic [31:0] devRxData, devTxData;
  logic irq;

  int nChk = 0, nFail = 0;
  logic gntEnable = 1'b1, rxEn = 1'b0, txEn = 1'b0, clrAll = 1'b0;
  logic [31:0] rxBase = '0, rxLimit = '0, rxIdx = '0, txIdx = '0;
  int grants = 0, reqRise = 0, irqEarly = 0;
  logic reqPrev = 1'b0;
  logic [31:0] bmem [0:1023];
  logic [31:0] txGot [0:15];

  always #2.5 clk = ~clk;

  dma_page_engine u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memGnt(memGnt), .devSel(devSel), .devRxValid(devRxValid),
    .devRxData(devRxData), .devRxReady(devRxReady), .devTxValid(devTxValid),
    .devTxData(devTxData), .devTxReady(devTxReady), .irq(irq)
  );

  assign devRxValid = rxEn && (rxIdx < rxLimit);
  assign devRxData = rxBase ^ (rxIdx * 32'h11);
  assign devTxReady = txEn;

  // memory and peripheral models plus monitors
  always @(posedge clk) begin
    memGnt <= memReq && !memGnt && gntEnable;
    memRdata <= bmem[memAddr[11:2]];
    if (memReq && memWe && memGnt) bmem[memAddr[11:2]] <= memWdata;
    reqPrev <= memReq;
    if (clrAll) begin
      rxIdx <= '0; txIdx <= '0; grants <= 0; reqRise <= 0; irqEarly <= 0;
    end else begin
      if (devRxValid && devRxReady) rxIdx <= rxIdx + 1;
      if (devTxValid && devTxReady) begin
        txGot[txIdx[3:0]] <= devTxData;
        txIdx <= txIdx + 1;
      end
      if (memReq && memGnt) grants <= grants + 1;
      if (memReq && !reqPrev) reqRise <= reqRise + 1;
      if (irq && memReq) irqEarly <= irqEarly + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic clearMon();
    @(negedge clk); clrAll = 1'b1;
    @(negedge clk); clrAll = 1'b0;
  endtask

  task automatic waitIrq(input string req);
    int n = 0;
    while (!irq && n < 2000) begin
      @(negedge clk); n++;
    end
    chk({req, " irq reached"}, {31'b0, irq}, 32'h1);
  endtask

  task automatic tReset();
    logic [31:0] d;
    regRd(4'hC, d);
    chk("R1 status after reset", d, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    chk("R1 idle handshakes", {29'b0, memReq, devRxReady, devTxValid}, 32'h0);
  endtask

  task automatic tDevToMem();
    logic [31:0] d;
    clearMon();
    rxBase = 32'hA5000000; rxLimit = 8; rxEn = 1'b1;
    regWr(4'h4, 32'h100);
    regWr(4'h8, 32);
    regWr(4'h0, 32'h31);
    chk("R4 devSel from control bits 7:4", {28'b0, devSel}, 32'h3);
    regRd(4'h0, d);
    chk("R4 control readback", d, 32'h30);
    waitIrq("R2");
    regRd(4'hC, d);
    chk("R2 status done", d, 32'h2);
    for (int i = 0; i < 8; i++)
      chk("R2 memory word", bmem[64 + i], 32'hA5000000 ^ (i * 32'h11));
    chk("R7 grant count", grants, 8);
    chk("R7 request per word", reqRise, 8);
    chk("R8 no irq mid transfer", irqEarly, 0);
    regWr(4'hC, 32'h2);
    chk("R8 irq drops after clear", {31'b0, irq}, 32'h0);
    rxEn = 1'b0;
  endtask

  task automatic tMemToDev();
    logic [31:0] d;
    for (int i = 0; i < 6; i++) bmem[128 + i] = 32'hC0DE0000 + i;
    clearMon();
    txEn = 1'b1;
    regWr(4'h4, 32'h200);
    regWr(4'h8, 24);
    regWr(4'h0, 32'h53);
    waitIrq("R3");
    chk("R3 words delivered", txIdx, 6);
    for (int i = 0; i < 6; i++) chk("R3 peripheral word", txGot[i], 32'hC0DE0000 + i);
    chk("R4 devSel second id", {28'b0, devSel}, 32'h5);
    regRd(4'hC, d);
    chk("R3 status done", d, 32'h2);
    regWr(4'hC, 32'h2);
    txEn = 1'b0;
  endtask

  task automatic tPageCross();
    logic [31:0] d;
    clearMon();
    rxEn = 1'b1; rxLimit = 4;
    regWr(4'h4, 32'hFF8);
    regWr(4'h8, 16);
    regWr(4'h0, 32'h01);
    regRd(4'hC, d);
    chk("R5 crossing sets error", d, 32'h4);
    chk("R5 crossing raises irq", {31'b0, irq}, 32'h1);
    repeat (4) @(negedge clk);
    chk("R5 no memory access", grants, 0);
    chk("R5 no peripheral word taken", rxIdx, 0);
    rxEn = 1'b0;
  endtask

  task automatic tPageExact();
    logic [31:0] d;
    clearMon();
    rxBase = 32'h5A000000; rxLimit = 4; rxEn = 1'b1;
    regWr(4'h4, 32'hFF0);
    regWr(4'h8, 16);
    regWr(4'h0, 32'h01);
    waitIrq("R5");
    regRd(4'hC, d);
    chk("R12 start cleared old error", d, 32'h2);
    for (int i = 0; i < 4; i++)
      chk("R5 page-end words", bmem[1020 + i], 32'h5A000000 ^ (i * 32'h11));
    regWr(4'hC, 32'h2);
    rxEn = 1'b0;
  endtask

  task automatic tBadCount();
    logic [31:0] d;
    clearMon();
    regWr(4'h4, 32'h100); regWr(4'h8, 6); regWr(4'h0, 32'h01);
    regRd(4'hC, d);
    chk("R6 count not multiple of 4", d, 32'h4);
    regWr(4'hC, 32'h4);
    regWr(4'h8, 0); regWr(4'h0, 32'h01);
    regRd(4'hC, d);
    chk("R6 zero count", d, 32'h4);
    regWr(4'hC, 32'h4);
    regWr(4'h4, 32'h102); regWr(4'h8, 4); regWr(4'h0, 32'h01);
    regRd(4'hC, d);
    chk("R6 unaligned address", d, 32'h4);
    chk("R6 no memory access", grants, 0);
  endtask

  task automatic tW1C();
    logic [31:0] d;
    regWr(4'hC, 32'h0);
    regRd(4'hC, d);
    chk("R9 zero write keeps error", d, 32'h4);
    regWr(4'hC, 32'h2);
    regRd(4'hC, d);
    chk("R9 done-bit write keeps error", d, 32'h4);
    chk("R9 irq still high", {31'b0, irq}, 32'h1);
    regWr(4'hC, 32'h4);
    regRd(4'hC, d);
    chk("R9 error cleared", d, 32'h0);
    chk("R9 irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic tBusyIgnore();
    logic [31:0] d;
    bmem[320] = 32'hDEADBEEF;
    clearMon();
    rxBase = 32'h77000000; rxLimit = 2; rxEn = 1'b0;
    regWr(4'h4, 32'h300); regWr(4'h8, 8); regWr(4'h0, 32'h01);
    regRd(4'hC, d);
    chk("R10 busy while stalled", d, 32'h1);
    regWr(4'h4, 32'h500); regWr(4'h8, 4); regWr(4'h0, 32'h73);
    regRd(4'h4, d); chk("R10 address write ignored", d, 32'h300);
    regRd(4'h8, d); chk("R10 count write ignored", d, 32'h8);
    regRd(4'h0, d); chk("R10 control write ignored", d, 32'h0);
    regRd(4'hC, d); chk("R10 restart ignored", d, 32'h1);
    rxEn = 1'b1;
    waitIrq("R10");
    chk("R10 first word at original address", bmem[192], 32'h77000000);
    chk("R10 second word", bmem[193], 32'h77000011);
    chk("R10 second target untouched", bmem[320], 32'hDEADBEEF);
    regWr(4'hC, 32'h2);
    rxEn = 1'b0;
  endtask

  task automatic tCollision();
    logic [31:0] d;
    int n = 0;
    clearMon();
    gntEnable = 1'b0;
    rxBase = 32'h12340000; rxLimit = 1; rxEn = 1'b1;
    regWr(4'h4, 32'h400); regWr(4'h8, 4); regWr(4'h0, 32'h01);
    while (!(memReq && memWe) && n < 100) begin @(negedge clk); n++; end
    gntEnable = 1'b1;
    @(negedge clk);
    chk("R11 grant arrives", {31'b0, memGnt}, 32'h1);
    regWe = 1'b1; regAddr = 4'hC; regWdata = 32'h2; gntEnable = 1'b0;
    @(negedge clk);
    regWe = 1'b0;
    gntEnable = 1'b1;
    regRd(4'hC, d);
    chk("R11 done survives same-cycle clear", d, 32'h2);
    chk("R11 irq high", {31'b0, irq}, 32'h1);
    chk("R11 word written", bmem[256], 32'h12340000);
    regWr(4'hC, 32'h2);
    regRd(4'hC, d);
    chk("R11 later clear works", d, 32'h0);
    rxEn = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) bmem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tDevToMem();
    tMemToDev();
    tPageCross();
    tPageExact();
    tBadCount();
    tW1C();
    tBusyIgnore();
    tCollision();
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule